// File: doc/BRIEF.md
# Frame Interrupt Pulse Generator

This block counts CPU T-states and pulls a maskable interrupt line low at the start of every video frame. It is clocked by the system clock and advances only on cycles where a T-state enable is high. The CPU may therefore run at any divided rate while the block still counts in T-states.

The frame length depends on a 4-bit CPU speed code. Speeds derived from the classic 3.5 MHz base use a frame of `BASE_LEN` T-states. Speeds derived from the VGA video clock use a longer frame of `VIDEO_LEN` T-states. This lets code that runs on a video-derived clock stay in step with the display.

The speed code is sampled only at a frame boundary, so each frame has the full length of exactly one period setting. A frame-start strobe marks the same T-state in which the interrupt goes low.

Top module: `frame_irq_gen`

## Requirements
- R1: While reset is low, and after reset until the first cycle with `tick` high, `irq_n` is 1 and `frame_start` is 0.
- R2: The first cycle with `tick` high after reset begins a frame: from that edge `irq_n` is 0 and `frame_start` is 1.
- R3: `frame_start` is 1 for exactly one enabled T-state per frame, and `irq_n` is 0 whenever `frame_start` is 1.
- R4: `irq_n` stays 0 for exactly `LOW_LEN` enabled T-states counted from the frame start, then returns to 1 until the next frame.
- R5: With an even speed code from 0 to 6, consecutive frame starts are `BASE_LEN` enabled T-states apart.
- R6: With an odd speed code from 1 to 7, consecutive frame starts are `VIDEO_LEN` enabled T-states apart.
- R7: With any speed code from 8 to 15, odd or even, consecutive frame starts are `BASE_LEN` enabled T-states apart.
- R8: Cycles with `tick` low neither advance the frame nor change `irq_n` or `frame_start`.
- R9: The speed code is sampled only when a frame begins. A change in the middle of a frame leaves that frame's length unchanged and applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | T-state enable, one high cycle per CPU T-state |
| speed_code | input | 4 | CPU speed selection; sets the frame length |
| irq_n | output | 1 | Active-low frame interrupt |
| frame_start | output | 1 | High during the first T-state of each frame |

## Verification
The bench builds the block with `BASE_LEN`=20, `VIDEO_LEN`=33 and `LOW_LEN`=4. With these values every speed code, both frame lengths and a speed change in the middle of a frame can be covered in a few thousand cycles. The two lengths differ and neither is a multiple of the other, so choosing the wrong period shows up as a different gap between frame starts. A pulse width of 4 lets the bench count every low T-state exactly. Idle cycles are placed inside the pulse, so a counter that ignores the enable changes the measured width.

// File: rtl/frame_irq_gen.sv
module frame_irq_gen #(
  parameter int BASE_LEN  = 69888,
  parameter int VIDEO_LEN = 104211,
  parameter int LOW_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] speed_code,
  output logic       irq_n,
  output logic       frame_start
);
  localparam int MAX_LEN = (BASE_LEN > VIDEO_LEN) ? BASE_LEN : VIDEO_LEN;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic          running;
  logic [CW-1:0] cnt;
  logic [CW-1:0] per;
  logic [CW-1:0] next_per;
  logic          wrap;

  assign next_per = ((speed_code <= 4'd7) && speed_code[0]) ? CW'(VIDEO_LEN) : CW'(BASE_LEN);
  assign wrap     = !running || (cnt == per - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      per     <= CW'(BASE_LEN);
    end else if (tick) begin
      running <= 1'b1;
      if (wrap) begin
        cnt <= '0;
        per <= next_per;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign frame_start = running && (cnt == '0);
  assign irq_n       = !(running && (cnt < CW'(LOW_LEN)));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !irq_n);

  assert_wrap_starts_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && cnt == per - CW'(1)) |=> frame_start);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(per) && $stable(running)));

  assert_period_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && cnt != per - CW'(1)) |=> $stable(per));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per);

  assert_legal_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per == CW'(BASE_LEN)) || (per == CW'(VIDEO_LEN)));
endmodule

// File: tb/frame_irq_gen_tb.sv
module frame_irq_gen_tb;
  localparam int BASE  = 20;
  localparam int VIDEO = 33;
  localparam int LOW   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] speed_code = 4'd0;
  logic       irq_n;
  logic       frame_start;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  frame_irq_gen #(.BASE_LEN(BASE), .VIDEO_LEN(VIDEO), .LOW_LEN(LOW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .speed_code(speed_code),
    .irq_n(irq_n), .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en);
    tick = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sync_start();
    for (int i = 0; i < 200; i++) begin
      step(1'b1);
      if (frame_start) return;
    end
    check(1'b0, "R2 sync", 0, 1);
  endtask

  task automatic measure(input string req, input int exp_len);
    int n = 0;
    int lows = 1;
    for (int i = 0; i < 200; i++) begin
      step(1'b1);
      n++;
      if (i == 0) check(frame_start == 1'b0, "R3 strobe one T-state", frame_start, 0);
      if (frame_start) break;
      if (!irq_n) lows++;
    end
    check(n == exp_len, req, n, exp_len);
    check(lows == LOW, "R4 pulse width", lows, LOW);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1'b1); step(1'b0);
    check(irq_n == 1'b1, "R1 irq_n in reset", irq_n, 1);
    check(frame_start == 1'b0, "R1 strobe in reset", frame_start, 0);
    rst_n = 1'b1;
    step(1'b0); step(1'b0);
    check(irq_n == 1'b1, "R1 irq_n before first tick", irq_n, 1);
    check(frame_start == 1'b0, "R1 strobe before first tick", frame_start, 0);
    step(1'b1);
    check(frame_start == 1'b1, "R2 first tick strobe", frame_start, 1);
    check(irq_n == 1'b0, "R2 first tick irq", irq_n, 0);
  endtask

  task automatic t_code(input logic [3:0] code, input string req, input int exp_len);
    speed_code = code;
    sync_start();
    check(irq_n == 1'b0, "R3 irq low at start", irq_n, 0);
    measure(req, exp_len);
  endtask

  task automatic t_idle();
    int n = 0;
    int lows = 1;
    speed_code = 4'd0;
    sync_start();
    step(1'b0); step(1'b0); step(1'b0);
    check(frame_start == 1'b1, "R8 strobe held over idle", frame_start, 1);
    check(irq_n == 1'b0, "R8 irq held over idle", irq_n, 0);
    for (int i = 0; i < 200; i++) begin
      step(1'b1);
      n++;
      if (frame_start) break;
      if (!irq_n) lows++;
      if (i < 6) begin
        step(1'b0);
        if (!irq_n) lows += 0;
      end
    end
    check(n == BASE, "R8 period with idle cycles", n, BASE);
    check(lows == LOW, "R8 pulse width with idle cycles", lows, LOW);
  endtask

  task automatic t_midchange();
    int n = 0;
    speed_code = 4'd0;
    sync_start();
    for (int i = 0; i < 5; i++) begin step(1'b1); n++; end
    speed_code = 4'd3;
    for (int i = 0; i < 200; i++) begin
      step(1'b1);
      n++;
      if (frame_start) break;
    end
    check(n == BASE, "R9 current frame keeps length", n, BASE);
    measure("R9 new length from next frame", VIDEO);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_code(4'd0, "R5 code 0", BASE);
    t_code(4'd2, "R5 code 2", BASE);
    t_code(4'd4, "R5 code 4", BASE);
    t_code(4'd6, "R5 code 6", BASE);
    t_code(4'd1, "R6 code 1", VIDEO);
    t_code(4'd3, "R6 code 3", VIDEO);
    t_code(4'd5, "R6 code 5", VIDEO);
    t_code(4'd7, "R6 code 7", VIDEO);
    t_code(4'd8, "R7 code 8", BASE);
    t_code(4'd9, "R7 code 9", BASE);
    t_code(4'd11, "R7 code 11", BASE);
    t_code(4'd15, "R7 code 15", BASE);
    t_idle();
    t_midchange();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule